// File: doc/BRIEF.md
# Dual-Channel Reloadable Down-Counter Timer

This block is a register-mapped timer with two independent down-counting channels. Each channel has a control/status word, a live count register and two reload registers. Software loads a start value into the first reload register, then writes the control word with count enable and the trigger bit set. The channel then counts down at half the input clock rate.

When the count steps past zero, the channel raises a sticky underflow flag. In reload mode the count is refilled from the first reload register and keeps running, so the underflow repeats with a fixed period. With reload mode off, the channel stops at zero until it is triggered again. Each channel drives a level interrupt. Software clears the flag by writing the control word back with that bit at zero.

Register access uses a single-cycle bus. `addr_i` is a word index equal to the byte offset divided by four. Writes take effect on the next rising clock edge. Read data is combinational from the address.

Top module: `dual_down_timer`

## Requirements
- R1: Word address bit 2 selects the channel. Bits 1:0 select the register: 0 control/status, 1 live count, 2 reload A, 3 reload B. This gives byte offsets 0x0/0x4/0x8/0xC per channel and a 0x10 stride between channels. After reset every register reads 0 and both interrupts are low.
- R2: The control word has these fields: bit 0 trigger (always reads 0), bit 1 count enable, bit 2 underflow flag, bit 3 interrupt enable, bit 4 reload mode and bit 5 level bit (stored and read back). Bits 31:6 read 0. A control write updates bits 1, 3, 4 and 5 from the written word.
- R3: A control write with bits 0 and 1 both set loads the count from reload A and restarts the divide-by-2 prescaler. The first decrement is seen two clocks after the write edge, and the count then falls by one every two clocks.
- R4: In reload mode, a count step taken at zero loads reload A and sets the underflow flag on that same edge. The flag therefore sets every 2*(A+1) clocks.
- R5: With reload mode clear, a count step taken at zero sets the underflow flag, leaves the count at 0 and stops the channel until the next trigger.
- R6: Writing the control word with bit 2 at 0 clears the underflow flag. Writing it with bit 2 at 1 leaves the flag unchanged. A hardware underflow on the same edge takes priority over the clear.
- R7: `irq_o[c]` is high exactly while channel c has both its underflow flag and its interrupt enable set.
- R8: While count enable is clear, the count and the prescaler hold their values. A control write with bit 0 set and bit 1 clear does not load the count. Setting count enable again without a trigger resumes from the held value.
- R9: Writing the count register replaces the count at any time, whether the channel is stopped or running. Reads return the live value.
- R10: Reload B is read/write storage and has no effect on counting.
- R11: The two channels are fully independent; activity on one never changes the registers or interrupt of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 3 | Word address: bit 2 channel, bits 1:0 register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 2 | Per-channel level interrupt |

## Verification
Every reload value from 0 to 4 is run on both channels in periodic and one-shot mode, for three full periods. The count and control word are compared in every clock against a closed-form model. This separates an off-by-one in the period, a wrong prescaler phase at trigger, and a reload that does not happen or happens in one-shot mode. Interrupts are enabled on one channel only, which shows whether the level is correctly gated by the enable. Directed sequences cover flag clear versus write-one, freezing the count mid-run, a trigger with enable clear, live count overwrites, and a check that the idle channel is left untouched.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CNT  = 2'd1;
  localparam logic [1:0] REG_RLDA = 2'd2;
  localparam logic [1:0] REG_RLDB = 2'd3;

  localparam int B_TRIG = 0;
  localparam int B_CNTE = 1;
  localparam int B_UF   = 2;
  localparam int B_INTE = 3;
  localparam int B_RELD = 4;
  localparam int B_LVL  = 5;
  localparam int CTRL_BITS = 6;
endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ph_q <= '0;
    else if (clr_i) ph_q <= '0;
    else if (en_i)  ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  assign tick_o = en_i && !clr_i && (ph_q == LAST);

  generate
    if (DIV >= 2) begin : g_chk
      assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
  import dtm_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [1:0]       reg_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, rlda_q, rldb_q;
  logic cnte_q, uf_q, inte_q, reld_q, lvl_q, run_q;
  logic wr, wr_ctrl, wr_cnt, trig, en, tick, uf_evt;

  assign wr      = sel_i && we_i;
  assign wr_ctrl = wr && (reg_i == REG_CTRL);
  assign wr_cnt  = wr && (reg_i == REG_CNT);
  assign trig    = wr_ctrl && wdata_i[B_TRIG] && wdata_i[B_CNTE];
  assign en      = cnte_q && run_q;
  assign uf_evt  = tick && (cnt_q == '0);

  dtm_prescaler #(.DIV(PRESCALE)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .clr_i  (trig),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnte_q <= 1'b0;
      inte_q <= 1'b0;
      reld_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else if (wr_ctrl) begin
      cnte_q <= wdata_i[B_CNTE];
      inte_q <= wdata_i[B_INTE];
      reld_q <= wdata_i[B_RELD];
      lvl_q  <= wdata_i[B_LVL];
    end
  end

  // hardware set wins over a software clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uf_q <= 1'b0;
    else         uf_q <= uf_evt || (uf_q && !(wr_ctrl && !wdata_i[B_UF]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= 1'b0;
    else if (trig)                run_q <= 1'b1;
    else if (uf_evt && !reld_q)   run_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (trig)    cnt_q <= rlda_q;
    else if (wr_cnt)  cnt_q <= wdata_i;
    else if (tick) begin
      if (cnt_q == '0) cnt_q <= reld_q ? rlda_q : '0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rlda_q <= '0;
      rldb_q <= '0;
    end else begin
      if (wr && reg_i == REG_RLDA) rlda_q <= wdata_i;
      if (wr && reg_i == REG_RLDB) rldb_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_i)
      REG_CTRL: begin
        rdata_o[B_CNTE] = cnte_q;
        rdata_o[B_UF]   = uf_q;
        rdata_o[B_INTE] = inte_q;
        rdata_o[B_RELD] = reld_q;
        rdata_o[B_LVL]  = lvl_q;
      end
      REG_CNT:  rdata_o = cnt_q;
      REG_RLDA: rdata_o = rlda_q;
      default:  rdata_o = rldb_q;
    endcase
  end

  assign irq_o = uf_q && inte_q;

  assert_trig_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> (cnt_q == $past(rlda_q)) && run_q);
  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_evt && reld_q && !trig && !wr_cnt) |=> (cnt_q == $past(rlda_q)) && uf_q);
  assert_oneshot_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_evt && !reld_q && !trig && !wr_cnt) |=> !run_q && (cnt_q == '0) && uf_q);
  assert_uf_no_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uf_q && !uf_evt) |=> !uf_q);
  assert_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnte_q && !trig && !wr_cnt) |=> $stable(cnt_q));
  assert_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(uf_evt || (wr_ctrl && wdata_i[B_INTE])));
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int N_CH     = 2,
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 2,
  localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int ADDR_W  = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [CNT_W-1:0] ch_rd [N_CH];
  logic [CH_W-1:0]  ch_sel;

  assign ch_sel = addr_i[ADDR_W-1:2];

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      dtm_channel #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_ch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (req_i && (ch_sel == CH_W'(c))),
        .we_i    (we_i),
        .reg_i   (addr_i[1:0]),
        .wdata_i (wdata_i),
        .rdata_o (ch_rd[c]),
        .irq_o   (irq_o[c])
      );
    end
  endgenerate

  assign rdata_o = ch_rd[ch_sel];

  assert_irq_known_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(irq_o));
endmodule

// File: tb/dual_down_timer_tb.sv
`timescale 1ns/1ps
module dual_down_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int n_cmp = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_down_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int ch, input int rg, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = {ch[0], rg[1:0]}; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input int ch, input int rg, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = {ch[0], rg[1:0]};
    #1;
    d = rdata;
    req = 1'b0;
  endtask

  task automatic sweep(input int ch, input int r, input bit reld, input bit inte);
    logic [31:0] v;
    int p;
    bus_wr(ch, 0, 32'h0);
    bus_wr(ch, 2, r);
    bus_wr(ch, 3, r + 3);
    bus_wr(ch, 0, 32'h3 | (32'(reld) << 4) | (32'(inte) << 3));
    p = 2 * (r + 1);
    for (int m = 0; m < 3 * p; m++) begin
      int ec;
      bit eu;
      eu = (m >= p);
      if (reld)       ec = r - (m % p) / 2;
      else if (m < p) ec = r - m / 2;
      else            ec = 0;
      bus_rd(ch, 1, v);
      chk(reld ? "R4 count" : "R5 count", v, ec);
      bus_rd(ch, 0, v);
      chk("R3/R6 ctrl", v, (32'(reld) << 4) | (32'(inte) << 3) | (32'(eu) << 2) | 32'h2);
      chk("R7 irq", {31'b0, irq[ch]}, {31'b0, eu & inte});
      @(negedge clk);
    end
    bus_rd(ch, 3, v);
    chk("R10 reload B", v, r + 3);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 2; c++)
      for (int g = 0; g < 4; g++) begin
        bus_rd(c, g, v);
        chk("R1 reset value", v, 0);
      end
    chk("R1 reset irq", {30'b0, irq}, 0);

    bus_wr(0, 3, 32'hA5A5_0001);
    bus_wr(1, 3, 32'h5A5A_0002);
    bus_rd(0, 3, v); chk("R10 reload B ch0", v, 32'hA5A5_0001);
    bus_rd(1, 3, v); chk("R10 reload B ch1", v, 32'h5A5A_0002);
    bus_wr(1, 1, 32'hDEAD_BEEF);
    bus_rd(1, 1, v); chk("R9 count write stopped", v, 32'hDEAD_BEEF);

    for (int rl = 0; rl < 2; rl++)
      for (int r = 0; r < 5; r++) sweep(0, r, rl[0], 1'b0);

    bus_rd(1, 1, v); chk("R11 other count", v, 32'hDEAD_BEEF);
    bus_rd(1, 0, v); chk("R11 other ctrl", v, 0);
    bus_rd(1, 3, v); chk("R11 other reload B", v, 32'h5A5A_0002);
    chk("R11 other irq", {31'b0, irq[1]}, 0);

    for (int rl = 0; rl < 2; rl++)
      for (int r = 0; r < 5; r++) sweep(1, r, rl[0], 1'b1);

    // flag clear semantics on a stopped one-shot channel
    bus_wr(0, 0, 32'h0);
    bus_wr(0, 2, 32'd2);
    bus_wr(0, 0, 32'h3);
    repeat (10) @(negedge clk);
    bus_rd(0, 0, v); chk("R5 stopped ctrl", v, 32'h6);
    bus_rd(0, 1, v); chk("R5 stopped count", v, 0);
    chk("R7 irq masked", {31'b0, irq[0]}, 0);
    bus_wr(0, 0, 32'h0E);
    bus_rd(0, 0, v); chk("R6 write one keeps", v, 32'h0E);
    chk("R7 irq on enable", {31'b0, irq[0]}, 1);
    bus_wr(0, 0, 32'h0A);
    bus_rd(0, 0, v); chk("R6 write zero clears", v, 32'h0A);
    chk("R7 irq after clear", {31'b0, irq[0]}, 0);
    repeat (10) @(negedge clk);
    bus_rd(0, 0, v); chk("R5 no restart", v, 32'h0A);
    bus_rd(0, 1, v); chk("R5 count held", v, 0);
    bus_wr(0, 0, 32'hFFFF_FFEA);
    bus_rd(0, 0, v); chk("R2 level and reserved", v, 32'h2A);

    // freeze, ignored trigger, resume
    bus_wr(1, 0, 32'h0);
    bus_wr(1, 2, 32'd1000);
    bus_wr(1, 0, 32'h13);
    repeat (20) @(negedge clk);
    bus_wr(1, 0, 32'h10);
    bus_rd(1, 1, v); chk("R8 frozen value", v, 32'd989);
    repeat (12) @(negedge clk);
    bus_rd(1, 1, v); chk("R8 held", v, 32'd989);
    bus_wr(1, 0, 32'h11);
    bus_rd(1, 1, v); chk("R8 trigger ignored", v, 32'd989);
    repeat (4) @(negedge clk);
    bus_rd(1, 1, v); chk("R8 still held", v, 32'd989);
    bus_wr(1, 0, 32'h12);
    repeat (10) @(negedge clk);
    bus_rd(1, 1, v);
    chk("R8 resumed", {31'b0, (v < 32'd989) && (v >= 32'd982)}, 1);
    bus_wr(1, 1, 32'h40);
    bus_rd(1, 1, v); chk("R9 count write running", v, 32'h40);
    bus_wr(1, 0, 32'h0);
    bus_wr(1, 1, 32'hFFFF_FFFF);
    bus_rd(1, 1, v); chk("R9 all ones", v, 32'hFFFF_FFFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule